// File: doc/BRIEF.md
# I2C Target Interface with Clock Stretching

This block is the target (responder) side of an I2C bus. It follows the shared clock and data lines, detects START, repeated START and STOP, and treats the first byte after any START as an address. It compares that address with a 7-bit identity supplied by the host logic, and it also answers the all-zero general call address. When a controller writes, each received byte goes into a one-deep receive holding register. When a controller reads, bytes come from a one-deep transmit holding register.

Both bus lines are open-drain. The block never drives a line high: it only asserts an output enable that pulls the line low. If the host side has not emptied the receive register, or has not filled the transmit register, by the time the next byte must be handled, the block holds SCL low until the host catches up. It reports that wait on a status output. A transaction stays open until a STOP arrives, or until a repeated START carries an address that does not match. The host logic uses single-cycle read and write strobes and a small set of status flags.

Top module: `i2cs_top`

## Requirements
- R1: When the address byte after a START carries this target's address, the block pulls SDA low during the ninth clock, sets `st_acc`, and sets `st_read` to the R/W bit (1 = controller reads, 0 = controller writes). Any other address, apart from the general call, is not acknowledged and leaves `st_acc` at 0.
- R2: In a write, each complete byte is stored in the receive register and acknowledged, and `st_rxrdy` goes to 1. A one-cycle `rhr_rd` pulse clears `st_rxrdy`.
- R3: Reception continues byte after byte, MSB first, until a STOP is seen or a repeated START brings a non-matching address.
- R4: A STOP during an access clears `st_acc` and sets `st_txcomp`. `st_txcomp` is cleared at the next address match.
- R5: A repeated START followed by a non-matching address clears `st_acc` and sets `st_txcomp`. A repeated START followed by a matching address keeps `st_acc` at 1 and updates `st_read` to the new direction.
- R6: In a read, the block sends the bytes written through `thr_wr`, MSB first, one byte for each byte the controller acknowledges.
- R7: If the transmit register is empty when the next read byte must start, the block holds SCL low and keeps `st_wait` at 1 until `thr_wr` arrives. The byte written then is sent.
- R8: If `st_rxrdy` is still 1 when another written byte completes, the block holds SCL low with `st_wait` at 1 until `rhr_rd`. The earlier byte stays readable and the new byte is not lost.
- R9: Address byte 0x00 with R/W = 0 is acknowledged and sets `st_gcall` and `st_acc` with `st_read` at 0. `st_gcall` is cleared by the next address decode that is not a general call.
- R10: After the controller answers a read byte with NACK, the block releases SDA and drives nothing until the next START or STOP. The transmit register is not consumed during that time.
- R11: The block changes SDA only while SCL is low. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or data 0) |
| own_addr | input | 7 | This target's 7-bit address |
| rhr_rd | input | 1 | Host read strobe for the receive register |
| rhr_data | output | 8 | Receive holding register |
| thr_wr | input | 1 | Host write strobe for the transmit register |
| thr_data | input | 8 | Byte to load into the transmit register |
| st_acc | output | 1 | Addressed and in an access |
| st_read | output | 1 | Direction of the current access, 1 = controller reads |
| st_rxrdy | output | 1 | Receive register holds an unread byte |
| st_txcomp | output | 1 | Last access has ended |
| st_gcall | output | 1 | General call received |
| st_wait | output | 1 | SCL is being held low |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a 7-bit address and two synchronizer stages. It drives the bus with a quarter bit period of 8 clocks, so the three-cycle delay from pin to edge event always falls inside the SCL low phase, while the host strobes can still be delayed long enough to force both kinds of stretch. A behavioural controller honours stretching by waiting for SCL to rise. Queues of expected receive and transmit bytes check every byte moved, through acknowledged writes, repeated STARTs, general calls and NACK-terminated reads.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int I2C_ADDR_W = 7;
    localparam int I2C_BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RXB,
        ST_RACK,
        ST_RXST,
        ST_TXB,
        ST_TACK,
        ST_TXLD,
        ST_SKIP
    } i2cs_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic is_stretch(input i2cs_state_e s);
        return (s == ST_TXLD) || (s == ST_RXST);
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= '1;
                else     pipe[g] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= '1;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
    import i2cs_pkg::*;
#(
    parameter int ADDR_W      = I2C_ADDR_W,
    parameter int DATA_W      = I2C_BYTE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rhr_rd,
    output logic [DATA_W-1:0] rhr_data,
    input  logic              thr_wr,
    input  logic [DATA_W-1:0] thr_data,
    output logic              st_acc,
    output logic              st_read,
    output logic              st_rxrdy,
    output logic              st_txcomp,
    output logic              st_gcall,
    output logic              st_wait
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

    logic [1:0]        line_s;
    logic              scl_s, sda_s;
    bus_ev_t           ev;
    i2cs_state_e       state;
    logic [DATA_W-1:0] sreg, rhr_q, thr_q;
    logic [CNT_W-1:0]  bitcnt;
    logic              thr_full, mack;
    logic              byte_done, own_hit, gc_hit;

    i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2cs_cond u_cond (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .ev(ev)
    );

    assign byte_done = (bitcnt == FULL_CNT);
    assign own_hit   = (sreg[DATA_W-1 -: ADDR_W] == own_addr);
    assign gc_hit    = (sreg == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sreg      <= '0;
            rhr_q     <= '0;
            thr_q     <= '0;
            bitcnt    <= '0;
            thr_full  <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            st_acc    <= 1'b0;
            st_read   <= 1'b0;
            st_rxrdy  <= 1'b0;
            st_txcomp <= 1'b0;
            st_gcall  <= 1'b0;
        end else begin
            if (rhr_rd) st_rxrdy <= 1'b0;
            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                if (st_acc) begin
                    st_acc    <= 1'b0;
                    st_txcomp <= 1'b1;
                end
            end else if (ev.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (ev.rise) begin
                            sreg   <= {sreg[DATA_W-2:0], sda_s};
                            bitcnt <= bitcnt + CNT_W'(1);
                        end else if (ev.fall && byte_done) begin
                            st_gcall <= gc_hit;
                            if (own_hit || gc_hit) begin
                                st_acc    <= 1'b1;
                                st_read   <= own_hit & sreg[0];
                                st_txcomp <= 1'b0;
                                sda_oe    <= 1'b1;
                                state     <= ST_AACK;
                            end else begin
                                if (st_acc) begin
                                    st_acc    <= 1'b0;
                                    st_txcomp <= 1'b1;
                                end
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_AACK, ST_TACK: begin
                        if (ev.rise && state == ST_TACK) begin
                            mack <= ~sda_s;
                        end else if (ev.fall) begin
                            bitcnt <= '0;
                            if (state == ST_AACK && !st_read) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RXB;
                            end else if (state == ST_TACK && !mack) begin
                                sda_oe <= 1'b0;
                                state  <= ST_SKIP;
                            end else if (thr_full) begin
                                sreg     <= thr_q;
                                thr_full <= 1'b0;
                                sda_oe   <= ~thr_q[DATA_W-1];
                                state    <= ST_TXB;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_TXLD;
                            end
                        end
                    end
                    ST_TXLD: begin
                        if (thr_full) begin
                            sreg     <= thr_q;
                            thr_full <= 1'b0;
                            sda_oe   <= ~thr_q[DATA_W-1];
                            bitcnt   <= '0;
                            state    <= ST_TXB;
                        end
                    end
                    ST_TXB: begin
                        if (ev.rise) begin
                            bitcnt <= bitcnt + CNT_W'(1);
                        end else if (ev.fall) begin
                            if (byte_done) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TACK;
                            end else begin
                                sreg   <= {sreg[DATA_W-2:0], 1'b0};
                                sda_oe <= ~sreg[DATA_W-2];
                            end
                        end
                    end
                    ST_RXB: begin
                        if (ev.rise) begin
                            sreg   <= {sreg[DATA_W-2:0], sda_s};
                            bitcnt <= bitcnt + CNT_W'(1);
                        end else if (ev.fall && byte_done) begin
                            if (!st_rxrdy) begin
                                rhr_q    <= sreg;
                                st_rxrdy <= 1'b1;
                                sda_oe   <= 1'b1;
                                state    <= ST_RACK;
                            end else begin
                                state <= ST_RXST;
                            end
                        end
                    end
                    ST_RXST: begin
                        if (!st_rxrdy) begin
                            rhr_q    <= sreg;
                            st_rxrdy <= 1'b1;
                            sda_oe   <= 1'b1;
                            state    <= ST_RACK;
                        end
                    end
                    ST_RACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_RXB;
                        end
                    end
                    default: ;
                endcase
            end
            if (thr_wr) begin
                thr_q    <= thr_data;
                thr_full <= 1'b1;
            end
        end
    end

    assign scl_oe   = is_stretch(state);
    assign st_wait  = scl_oe;
    assign rhr_data = rhr_q;

    // Assertions
    assert_ack_on_match_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(st_acc) |-> sda_oe);

    assert_read_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (rhr_rd && st_rxrdy) |=> !st_rxrdy);

    assert_stop_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && st_acc) |=> (!st_acc && st_txcomp));

    assert_gcall_write_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(st_gcall) |-> (st_acc && !st_read));

    assert_sda_low_phase_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

    assert_nack_release_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> (!sda_oe && !scl_oe));
endmodule

// File: tb/tb_i2cs_top.sv
`timescale 1ns/1ps
module tb_i2cs_top;
    localparam int Q = 8;
    localparam logic [6:0] OWN = 7'h3A;
    localparam logic [6:0] OTHER = 7'h15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic m_scl_oe = 1'b0, m_sda_oe = 1'b0;
    logic scl_oe, sda_oe;
    logic scl_line, sda_line;
    logic rhr_rd = 1'b0, thr_wr = 1'b0;
    logic [7:0] thr_data = 8'h00, rhr_data;
    logic st_acc, st_read, st_rxrdy, st_txcomp, st_gcall, st_wait;

    assign scl_line = ~(m_scl_oe | scl_oe);
    assign sda_line = ~(m_sda_oe | sda_oe);

    i2cs_top dut (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
        .rhr_rd(rhr_rd), .rhr_data(rhr_data), .thr_wr(thr_wr), .thr_data(thr_data),
        .st_acc(st_acc), .st_read(st_read), .st_rxrdy(st_rxrdy),
        .st_txcomp(st_txcomp), .st_gcall(st_gcall), .st_wait(st_wait)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R11: SDA from the block may change only while SCL is low
    logic prev_sda_oe = 1'b0, prev_scl = 1'b1;
    always begin
        @(posedge clk); #1;
        if (!rst) begin
            if (sda_oe !== prev_sda_oe) begin
                checks++;
                if (scl_line && prev_scl) begin
                    errors++;
                    $display("FAIL R11: sda_oe changed to %0b while SCL high, expected change only while low", sda_oe);
                end
            end
            if (st_wait !== scl_oe) begin
                errors++;
                $display("FAIL R7: st_wait %0b expected %0b (scl hold)", st_wait, scl_oe);
            end
        end
        prev_sda_oe = sda_oe;
        prev_scl = scl_line;
    end

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_bit(input logic b, output logic r);
        m_sda_oe = ~b;
        waitn(Q);
        m_scl_oe = 1'b0;
        while (!scl_line) @(negedge clk);
        waitn(Q);
        r = sda_line;
        waitn(Q);
        m_scl_oe = 1'b1;
        waitn(Q);
    endtask

    task automatic m_start();
        m_sda_oe = 1'b1; waitn(2*Q);
        m_scl_oe = 1'b1; waitn(Q);
    endtask

    task automatic m_rstart();
        m_sda_oe = 1'b0; waitn(Q);
        m_scl_oe = 1'b0;
        while (!scl_line) @(negedge clk);
        waitn(2*Q);
        m_sda_oe = 1'b1; waitn(2*Q);
        m_scl_oe = 1'b1; waitn(Q);
    endtask

    task automatic m_stop();
        m_sda_oe = 1'b1; waitn(Q);
        m_scl_oe = 1'b0;
        while (!scl_line) @(negedge clk);
        waitn(2*Q);
        m_sda_oe = 1'b0; waitn(2*Q);
    endtask

    task automatic m_wbyte(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(v[i], r);
        m_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic m_rbyte(input logic ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(1'b1, v[i]);
        m_bit(~ack, r);
    endtask

    task automatic h_read(input string tag);
        logic [7:0] e;
        e = (rxq.size() > 0) ? rxq.pop_front() : 8'hxx;
        chk(tag, rhr_data, e);
        rhr_rd = 1'b1; @(negedge clk); rhr_rd = 1'b0; @(negedge clk);
    endtask

    task automatic h_write(input logic [7:0] v);
        thr_data = v; thr_wr = 1'b1; txq.push_back(v);
        @(negedge clk); thr_wr = 1'b0;
    endtask

    task automatic w_data(input logic [7:0] v, input string tag);
        logic ack;
        m_wbyte(v, ack);
        chk(tag, ack, 1'b1);
        rxq.push_back(v);
    endtask

    task automatic r_data(input logic ack, input string tag);
        logic [7:0] v, e;
        m_rbyte(ack, v);
        e = (txq.size() > 0) ? txq.pop_front() : 8'hxx;
        chk(tag, v, e);
    endtask

    initial begin
        logic ack;
        waitn(5);
        rst = 1'b0;
        waitn(5);
        // reset state
        chk("reset flags", {st_acc, st_read, st_rxrdy, st_txcomp, st_gcall, st_wait}, 6'b0);
        chk("reset lines", {scl_oe, sda_oe}, 2'b00);

        // R1: foreign address is not acknowledged
        m_start();
        m_wbyte({OTHER, 1'b0}, ack);
        chk("R1 foreign nack", ack, 1'b0);
        chk("R1 foreign acc", st_acc, 1'b0);
        m_wbyte(8'h77, ack);
        chk("R1 ignored byte rxrdy", st_rxrdy, 1'b0);
        m_stop();
        chk("R4 no access no txcomp", st_txcomp, 1'b0);

        // R1/R2/R3/R4: write two bytes
        m_start();
        m_wbyte({OWN, 1'b0}, ack);
        chk("R1 own ack", ack, 1'b1);
        chk("R1 acc/read", {st_acc, st_read}, 2'b10);
        w_data(8'hA5, "R2 data ack");
        chk("R2 rxrdy set", st_rxrdy, 1'b1);
        h_read("R2 first byte");
        chk("R2 rxrdy cleared", st_rxrdy, 1'b0);
        w_data(8'h3C, "R3 second ack");
        h_read("R3 second byte");
        m_stop();
        chk("R4 stop flags", {st_acc, st_txcomp}, 2'b01);

        // R8: receive stretch
        m_start();
        m_wbyte({OWN, 1'b0}, ack);
        chk("R4 txcomp cleared on match", st_txcomp, 1'b0);
        w_data(8'h11, "R8 byte one ack");
        fork
            w_data(8'h22, "R8 byte two ack");
            begin
                waitn(400);
                chk("R8 wait", {st_wait, scl_oe, scl_line}, 3'b110);
                h_read("R8 held byte");
            end
        join
        chk("R8 wait released", st_wait, 1'b0);
        h_read("R8 stored byte");

        // R5: repeated START with non-matching address
        m_rstart();
        m_wbyte({OTHER, 1'b0}, ack);
        chk("R5 foreign nack", ack, 1'b0);
        chk("R5 acc/txcomp", {st_acc, st_txcomp}, 2'b01);
        m_stop();

        // R6/R7/R10: read with transmit stretch and NACK
        h_write(8'hC3);
        m_start();
        m_wbyte({OWN, 1'b1}, ack);
        chk("R1 read ack", ack, 1'b1);
        chk("R1 read acc/read", {st_acc, st_read}, 2'b11);
        r_data(1'b1, "R6 first read byte");
        fork
            r_data(1'b0, "R7 stretched byte");
            begin
                waitn(60);
                chk("R7 wait", {st_wait, scl_line}, 2'b10);
                h_write(8'h5E);
            end
        join
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sda_oe !== 1'b0) begin
                chk("R10 released after nack", sda_oe, 1'b0);
                break;
            end
        end
        chk("R10 released", {sda_oe, scl_oe}, 2'b00);
        h_write(8'h99);
        m_stop();
        chk("R4 read end", {st_acc, st_txcomp}, 2'b01);

        // R5: repeated START with matching address, direction changes
        m_start();
        m_wbyte({OWN, 1'b0}, ack);
        w_data(8'h44, "R3 write before rstart");
        h_read("R3 byte before rstart");
        m_rstart();
        m_wbyte({OWN, 1'b1}, ack);
        chk("R5 match ack", ack, 1'b1);
        chk("R5 acc kept read set", {st_acc, st_read, st_txcomp}, 3'b110);
        r_data(1'b0, "R10 unconsumed byte");
        m_stop();

        // R9: general call
        m_start();
        m_wbyte(8'h00, ack);
        chk("R9 gcall ack", ack, 1'b1);
        chk("R9 flags", {st_gcall, st_acc, st_read}, 3'b110);
        w_data(8'h06, "R9 gcall data ack");
        h_read("R9 gcall byte");
        m_stop();
        m_start();
        m_wbyte({OWN, 1'b0}, ack);
        chk("R9 gcall cleared", {st_gcall, st_acc}, 2'b01);
        m_stop();

        waitn(10);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule